// File: doc/BRIEF.md
# SPI Transfer Request Capability Checker

This block checks a single SPI transfer request against the controller's fixed capability set before the transfer is allowed to start. The capability inputs state what the controller can do: the number of chip selects, which lane widths it offers in each direction, which clock phase and polarity settings and mode options it allows, a mask of supported word sizes, the highest clock frequency, and the largest delay it can insert at each of four points. The request header names a chip select, a word size, a lane width for each direction, the mode bits, a per-transfer chip-select toggle, a frequency and four delays.

A request enters on a valid/ready handshake. In the cycle after the handshake the block returns a two-bit status with a one-cycle valid pulse. The status is OK (0), parameter error (1) for values that are malformed whatever the capabilities say, or unsupported (2) for well-formed values that this controller cannot honour. A parameter error wins over an unsupported feature.

Top module: `spi_req_checker`

## Requirements
- R1: During reset `respValid` and `reqReady` are low. From the first clock edge after reset is released, `reqReady` is high.
- R2: Each request accepted at a clock edge (`reqValid` and `reqReady` both high) gives exactly one `respValid` pulse, one cycle wide, after that edge. No pulse appears without an accepted request.
- R3: The status is 0 when every check passes, 1 when any parameter check fails, and 2 when no parameter check fails but some support check fails.
- R4: Each lane-width request (`reqTxLanes`, `reqRxLanes`) must be 0 or 1 (single), 2 (dual), 4 (quad) or 8 (octal). Any other value is a parameter error.
- R5: A lane capability vector uses bit 0 for dual, bit 1 for quad and bit 2 for octal. A request for a width whose bit is clear is unsupported. Single lane is always supported.
- R6: `reqMode` bit 0 is clock phase and bit 1 is clock polarity. The phase capability is `capModes[1:0]` and the polarity capability is `capModes[3:2]`. For each, 00 allows both settings, 01 allows only 0, 10 allows only 1, and 11 allows neither. A request for a setting that is not allowed is unsupported.
- R7: `reqMode` bit 2 (active-high chip select) needs `capModes[4]`, bit 3 (LSB first) needs `capModes[5]`, and bit 4 (loopback) needs `capModes[6]`. When such a request bit is set and its capability bit is clear, the request is unsupported. When a request bit is clear, it is always allowed.
- R8: A word size outside 1 to 32 is a parameter error. When `capBpwMask` is nonzero and its bit (size − 1) is clear, the request is unsupported. A zero mask allows every size.
- R9: When `capFreqMax` is zero there is no limit on frequency. Otherwise a `reqFreq` above it is unsupported.
- R10: The four delays are packed 32 bits each in `reqDelays` and `capDelayMax`: index 0 is word delay, 1 is chip-select setup, 2 is hold, 3 is inactive. A request above its maximum is unsupported. A maximum of zero means that delay is not available, so any nonzero request for it is unsupported.
- R11: A chip-select index at or above `capCsCount` is a parameter error.
- R12: Setting `reqCsChange` while `capCsChange` is low is unsupported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block accepts a request |
| reqCs | input | 8 | Chip-select index |
| reqBpw | input | 8 | Bits per word |
| reqTxLanes | input | 8 | Write lane-width code |
| reqRxLanes | input | 8 | Read lane-width code |
| reqMode | input | 5 | Phase, polarity, active-high CS, LSB first, loopback |
| reqCsChange | input | 1 | Toggle chip select after this transfer |
| reqFreq | input | 32 | Requested clock frequency |
| reqDelays | input | 128 | Four requested delays |
| capCsCount | input | 8 | Number of chip selects |
| capCsChange | input | 1 | Chip-select toggle supported |
| capTxLanes | input | 3 | Write lane widths supported |
| capRxLanes | input | 3 | Read lane widths supported |
| capBpwMask | input | 32 | Supported word sizes, zero means any |
| capModes | input | 7 | Phase/polarity encodings and option enables |
| capFreqMax | input | 32 | Highest frequency, zero means unlimited |
| capDelayMax | input | 128 | Four delay maxima, zero means unavailable |
| respValid | output | 1 | Status valid pulse |
| respStatus | output | 2 | 0 OK, 1 parameter error, 2 unsupported |

## Verification
The hardest outcome to produce from the ports is the mix where a parameter error and a support failure occur in the same request, and a fully legal request that lands exactly on a limit. Random requests that are drawn freely almost never pass every check. The stimulus therefore first builds a request that fits the random capabilities, then breaks zero, one or two chosen fields. Directed cases add the exact boundaries: a value equal to its maximum, zero maxima, a zero mask, word sizes 1 and 32, and the capability code 11.

// File: rtl/spi_chk_pkg.sv
package spi_chk_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PARAM = 2'd1,
    ST_UNSUP = 2'd2
  } chkStatus_e;

  typedef struct packed {
    logic load;
    logic emit;
  } ctrlStrobe_t;

endpackage

// File: rtl/spi_chk_lane.sv
module spi_chk_lane #(
  parameter int CODE_W = 8,
  parameter int CAP_W  = 3
) (
  input  logic [CODE_W-1:0] laneCode,
  input  logic [CAP_W-1:0]  laneCap,
  output logic              codeBad,
  output logic              codeUnsup
);
  always_comb begin
    codeBad   = 1'b0;
    codeUnsup = 1'b0;
    case (laneCode)
      CODE_W'(0), CODE_W'(1): ;
      CODE_W'(2): codeUnsup = !laneCap[0];
      CODE_W'(4): codeUnsup = !laneCap[1];
      CODE_W'(8): codeUnsup = !laneCap[2];
      default:    codeBad   = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_chk_limit.sv
module spi_chk_limit #(
  parameter int VAL_W          = 32,
  parameter bit ZERO_UNLIMITED = 1'b0
) (
  input  logic [VAL_W-1:0] reqVal,
  input  logic [VAL_W-1:0] maxVal,
  output logic             overLimit
);
  generate
    if (ZERO_UNLIMITED) begin : gUnlimited
      assign overLimit = (maxVal != '0) && (reqVal > maxVal);
    end else begin : gUnsupported
      // zero maximum: only a zero request fits
      assign overLimit = reqVal > maxVal;
    end
  endgenerate
endmodule

// File: rtl/spi_chk_ctrl.sv
module spi_chk_ctrl
  import spi_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        respValid,
  output ctrlStrobe_t strobe
);
  logic readyQ;
  logic respQ;
  logic fire;

  assign fire = reqValid && readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      respQ  <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      respQ  <= fire;
    end
  end

  assign reqReady    = readyQ;
  assign respValid   = respQ;
  assign strobe.load = fire;
  assign strobe.emit = respQ;

  // R2
  resp_after_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> respValid);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !respValid);
endmodule

// File: rtl/spi_chk_datapath.sv
module spi_chk_datapath
  import spi_chk_pkg::*;
#(
  parameter int VAL_W   = 32,
  parameter int IDX_W   = 8,
  parameter int MAX_BPW = 32,
  parameter int NUM_DLY = 4,
  parameter int LANE_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [IDX_W-1:0]         reqCs,
  input  logic [IDX_W-1:0]         reqBpw,
  input  logic [IDX_W-1:0]         reqTxLanes,
  input  logic [IDX_W-1:0]         reqRxLanes,
  input  logic [4:0]               reqMode,
  input  logic                     reqCsChange,
  input  logic [VAL_W-1:0]         reqFreq,
  input  logic [NUM_DLY*VAL_W-1:0] reqDelays,
  input  logic [IDX_W-1:0]         capCsCount,
  input  logic                     capCsChange,
  input  logic [LANE_W-1:0]        capTxLanes,
  input  logic [LANE_W-1:0]        capRxLanes,
  input  logic [MAX_BPW-1:0]       capBpwMask,
  input  logic [6:0]               capModes,
  input  logic [VAL_W-1:0]         capFreqMax,
  input  logic [NUM_DLY*VAL_W-1:0] capDelayMax,
  output logic [1:0]               status
);
  localparam int BPW_IDX_W = $clog2(MAX_BPW);

  logic [1:0]         laneBad;
  logic [1:0]         laneUnsup;
  logic [NUM_DLY-1:0] dlyOver;
  logic               freqOver;
  logic               csBad;
  logic               bpwBad;
  logic               bpwUnsup;
  logic [IDX_W-1:0]   bpwMinus1;
  logic               phaseBad;
  logic               polBad;
  logic               optBad;
  logic               paramErr;
  logic               unsupErr;
  chkStatus_e         statusQ;

  generate
    for (genvar d = 0; d < 2; d++) begin : gLane
      spi_chk_lane #(.CODE_W(IDX_W), .CAP_W(LANE_W)) laneChk (
        .laneCode  (d == 0 ? reqTxLanes : reqRxLanes),
        .laneCap   (d == 0 ? capTxLanes : capRxLanes),
        .codeBad   (laneBad[d]),
        .codeUnsup (laneUnsup[d])
      );
    end
    for (genvar k = 0; k < NUM_DLY; k++) begin : gDelay
      spi_chk_limit #(.VAL_W(VAL_W), .ZERO_UNLIMITED(1'b0)) dlyChk (
        .reqVal    (reqDelays[k*VAL_W +: VAL_W]),
        .maxVal    (capDelayMax[k*VAL_W +: VAL_W]),
        .overLimit (dlyOver[k])
      );
    end
  endgenerate

  spi_chk_limit #(.VAL_W(VAL_W), .ZERO_UNLIMITED(1'b1)) freqChk (
    .reqVal    (reqFreq),
    .maxVal    (capFreqMax),
    .overLimit (freqOver)
  );

  function automatic logic settingBad(input logic [1:0] capCode, input logic want);
    case (capCode)
      2'b00:   return 1'b0;
      2'b01:   return want;
      2'b10:   return !want;
      default: return 1'b1;
    endcase
  endfunction

  always_comb begin
    csBad     = reqCs >= capCsCount;
    bpwBad    = (reqBpw == '0) || (reqBpw > IDX_W'(MAX_BPW));
    bpwMinus1 = reqBpw - IDX_W'(1);
    bpwUnsup  = !bpwBad && (capBpwMask != '0) &&
                !capBpwMask[bpwMinus1[BPW_IDX_W-1:0]];
    phaseBad  = settingBad(capModes[1:0], reqMode[0]);
    polBad    = settingBad(capModes[3:2], reqMode[1]);
    optBad    = |(reqMode[4:2] & ~capModes[6:4]);
    paramErr  = (|laneBad) || csBad || bpwBad;
    unsupErr  = (|laneUnsup) || phaseBad || polBad || optBad || bpwUnsup ||
                freqOver || (|dlyOver) || (reqCsChange && !capCsChange);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= ST_OK;
    end else if (strobe.load) begin
      if (paramErr)      statusQ <= ST_PARAM;
      else if (unsupErr) statusQ <= ST_UNSUP;
      else               statusQ <= ST_OK;
    end
  end

  assign status = statusQ;

  // R11
  cs_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqCs >= capCsCount) |=> statusQ == ST_PARAM);
  // R4
  lane_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !(reqTxLanes inside {8'd0, 8'd1, 8'd2, 8'd4, 8'd8}))
      |=> statusQ == ST_PARAM);
  // R12
  cs_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqCsChange && !capCsChange) |=> statusQ != ST_OK);
  // R3
  status_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> statusQ inside {ST_OK, ST_PARAM, ST_UNSUP});
endmodule

// File: rtl/spi_req_checker.sv
module spi_req_checker
  import spi_chk_pkg::*;
#(
  parameter int VAL_W   = 32,
  parameter int IDX_W   = 8,
  parameter int MAX_BPW = 32,
  parameter int NUM_DLY = 4,
  parameter int LANE_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [IDX_W-1:0]         reqCs,
  input  logic [IDX_W-1:0]         reqBpw,
  input  logic [IDX_W-1:0]         reqTxLanes,
  input  logic [IDX_W-1:0]         reqRxLanes,
  input  logic [4:0]               reqMode,
  input  logic                     reqCsChange,
  input  logic [VAL_W-1:0]         reqFreq,
  input  logic [NUM_DLY*VAL_W-1:0] reqDelays,
  input  logic [IDX_W-1:0]         capCsCount,
  input  logic                     capCsChange,
  input  logic [LANE_W-1:0]        capTxLanes,
  input  logic [LANE_W-1:0]        capRxLanes,
  input  logic [MAX_BPW-1:0]       capBpwMask,
  input  logic [6:0]               capModes,
  input  logic [VAL_W-1:0]         capFreqMax,
  input  logic [NUM_DLY*VAL_W-1:0] capDelayMax,
  output logic                     respValid,
  output logic [1:0]               respStatus
);
  ctrlStrobe_t strobe;

  spi_chk_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .respValid (respValid),
    .strobe    (strobe)
  );

  spi_chk_datapath #(
    .VAL_W(VAL_W), .IDX_W(IDX_W), .MAX_BPW(MAX_BPW),
    .NUM_DLY(NUM_DLY), .LANE_W(LANE_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqCs       (reqCs),
    .reqBpw      (reqBpw),
    .reqTxLanes  (reqTxLanes),
    .reqRxLanes  (reqRxLanes),
    .reqMode     (reqMode),
    .reqCsChange (reqCsChange),
    .reqFreq     (reqFreq),
    .reqDelays   (reqDelays),
    .capCsCount  (capCsCount),
    .capCsChange (capCsChange),
    .capTxLanes  (capTxLanes),
    .capRxLanes  (capRxLanes),
    .capBpwMask  (capBpwMask),
    .capModes    (capModes),
    .capFreqMax  (capFreqMax),
    .capDelayMax (capDelayMax),
    .status      (respStatus)
  );
endmodule

// File: tb/spi_req_checker_tb.sv
`timescale 1ns/1ps
module spi_req_checker_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [7:0]   reqCs = '0, reqBpw = 8'd8, reqTxLanes = '0, reqRxLanes = '0;
  logic [4:0]   reqMode = '0;
  logic         reqCsChange = 1'b0;
  logic [31:0]  reqFreq = '0;
  logic [127:0] reqDelays = '0;
  logic [7:0]   capCsCount = 8'd4;
  logic         capCsChange = 1'b1;
  logic [2:0]   capTxLanes = '0, capRxLanes = '0;
  logic [31:0]  capBpwMask = '0;
  logic [6:0]   capModes = '0;
  logic [31:0]  capFreqMax = '0;
  logic [127:0] capDelayMax = '0;
  logic         respValid;
  logic [1:0]   respStatus;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_req_checker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCs(reqCs), .reqBpw(reqBpw), .reqTxLanes(reqTxLanes), .reqRxLanes(reqRxLanes),
    .reqMode(reqMode), .reqCsChange(reqCsChange), .reqFreq(reqFreq),
    .reqDelays(reqDelays), .capCsCount(capCsCount), .capCsChange(capCsChange),
    .capTxLanes(capTxLanes), .capRxLanes(capRxLanes), .capBpwMask(capBpwMask),
    .capModes(capModes), .capFreqMax(capFreqMax), .capDelayMax(capDelayMax),
    .respValid(respValid), .respStatus(respStatus)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // lane model: 0 ok, 1 malformed, 2 unsupported
  function automatic int laneModel(input logic [7:0] c, input logic [2:0] cap);
    if (c == 0 || c == 1) return 0;
    if (c == 2) return cap[0] ? 0 : 2;
    if (c == 4) return cap[1] ? 0 : 2;
    if (c == 8) return cap[2] ? 0 : 2;
    return 1;
  endfunction

  function automatic bit settingOk(input logic [1:0] cc, input logic v);
    return (cc == 2'b00) || (cc == 2'b01 && !v) || (cc == 2'b10 && v);
  endfunction

  function automatic int expected();
    bit p = 0, u = 0;
    int lt = laneModel(reqTxLanes, capTxLanes);
    int lr = laneModel(reqRxLanes, capRxLanes);
    if (lt == 1 || lr == 1) p = 1;
    if (lt == 2 || lr == 2) u = 1;
    if (reqCs >= capCsCount) p = 1;
    if (reqBpw < 1 || reqBpw > 32) p = 1;
    else if (capBpwMask != 0 && capBpwMask[reqBpw - 1] == 1'b0) u = 1;
    if (!settingOk(capModes[1:0], reqMode[0])) u = 1;
    if (!settingOk(capModes[3:2], reqMode[1])) u = 1;
    if (reqMode[2] && !capModes[4]) u = 1;
    if (reqMode[3] && !capModes[5]) u = 1;
    if (reqMode[4] && !capModes[6]) u = 1;
    if (capFreqMax != 0 && reqFreq > capFreqMax) u = 1;
    for (int k = 0; k < 4; k++) begin
      if (capDelayMax[k*32 +: 32] == 0) begin
        if (reqDelays[k*32 +: 32] != 0) u = 1;
      end else if (reqDelays[k*32 +: 32] > capDelayMax[k*32 +: 32]) u = 1;
    end
    if (reqCsChange && !capCsChange) u = 1;
    return p ? 1 : (u ? 2 : 0);
  endfunction

  task automatic send(input string tag);
    int e = expected();
    @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R2 valid"}, int'(respValid), 1);
    check(tag, int'(respStatus), e);
  endtask

  task automatic baseline();
    capCsCount = 8'd4; capCsChange = 1'b1; capTxLanes = 3'b111; capRxLanes = 3'b111;
    capBpwMask = '0; capModes = 7'h70; capFreqMax = '0;
    capDelayMax = {4{32'd100}};
    reqCs = 8'd0; reqBpw = 8'd8; reqTxLanes = 8'd1; reqRxLanes = 8'd0;
    reqMode = '0; reqCsChange = 1'b0; reqFreq = 32'd1000; reqDelays = '0;
  endtask

  task automatic randLegal();
    capCsCount  = 8'($urandom_range(1, 16));
    capCsChange = 1'($urandom);
    capTxLanes  = 3'($urandom);
    capRxLanes  = 3'($urandom);
    capBpwMask  = ($urandom_range(0, 3) == 0) ? 32'd0 : ($urandom | 32'h80);
    capModes    = {3'($urandom), 2'($urandom_range(0, 2)), 2'($urandom_range(0, 2))};
    capFreqMax  = ($urandom_range(0, 3) == 0) ? 32'd0 : 32'($urandom_range(1000, 50000));
    for (int k = 0; k < 4; k++)
      capDelayMax[k*32 +: 32] = ($urandom_range(0, 2) == 0) ? 32'd0 : 32'($urandom_range(1, 500));
    reqCs = 8'($urandom_range(0, int'(capCsCount) - 1));
    reqBpw = 8'd8;
    reqTxLanes = 8'd1; reqRxLanes = 8'd0;
    reqMode = {3'($urandom) & capModes[6:4],
               capModes[3:2] == 2'b10, capModes[1:0] == 2'b10};
    reqCsChange = capCsChange & 1'($urandom);
    reqFreq = (capFreqMax == 0) ? $urandom : 32'($urandom_range(0, int'(capFreqMax)));
    for (int k = 0; k < 4; k++)
      reqDelays[k*32 +: 32] = 32'($urandom_range(0, int'(capDelayMax[k*32 +: 32])));
  endtask

  task automatic randBreak();
    case ($urandom_range(0, 9))
      0: reqCs = 8'($urandom_range(0, 20));
      1: reqBpw = 8'($urandom_range(0, 40));
      2: reqTxLanes = 8'($urandom_range(0, 9));
      3: reqRxLanes = 8'($urandom_range(0, 9));
      4: reqMode = 5'($urandom);
      5: reqCsChange = 1'b1;
      6: reqFreq = reqFreq + 32'($urandom_range(0, 2000));
      7: reqDelays[$urandom_range(0, 3)*32 +: 32] = 32'($urandom_range(0, 600));
      8: capModes[1:0] = 2'($urandom);
      default: ;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    baseline();
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(respValid), 0);
    check("R1 reset ready", int'(reqReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(reqReady), 1);
    check("R1 idle valid", int'(respValid), 0);

    baseline(); send("R3 ok");
    @(negedge clk); check("R2 single pulse", int'(respValid), 0);
    // back to back requests
    @(negedge clk); reqValid = 1'b1;
    @(negedge clk); check("R2 b2b first", int'(respValid), 1);
    @(negedge clk); reqValid = 1'b0; check("R2 b2b second", int'(respValid), 1);
    @(negedge clk); check("R2 b2b end", int'(respValid), 0);

    baseline(); reqTxLanes = 8'd3; send("R4 tx code 3");
    baseline(); reqRxLanes = 8'd16; send("R4 rx code 16");
    baseline(); reqRxLanes = 8'd8; send("R4 octal ok");
    baseline(); capTxLanes = 3'b101; reqTxLanes = 8'd4; send("R5 quad missing");
    baseline(); capRxLanes = 3'b000; reqRxLanes = 8'd1; send("R5 single always");
    baseline(); capRxLanes = 3'b110; reqRxLanes = 8'd2; send("R5 dual missing");
    baseline(); capModes[1:0] = 2'b01; reqMode[0] = 1'b1; send("R6 phase only0");
    baseline(); capModes[3:2] = 2'b10; reqMode[1] = 1'b1; send("R6 pol only1 ok");
    baseline(); capModes[3:2] = 2'b10; reqMode[1] = 1'b0; send("R6 pol only1");
    baseline(); capModes[1:0] = 2'b11; send("R6 code 11");
    baseline(); capModes[4] = 1'b0; reqMode[2] = 1'b1; send("R7 cs high");
    baseline(); capModes[5] = 1'b0; reqMode[3] = 1'b1; send("R7 lsb");
    baseline(); capModes[6] = 1'b0; reqMode[4] = 1'b1; send("R7 loopback");
    baseline(); reqMode[4:2] = 3'b111; send("R7 all allowed");
    baseline(); reqBpw = 8'd0; send("R8 size 0");
    baseline(); reqBpw = 8'd33; send("R8 size 33");
    baseline(); reqBpw = 8'd32; capBpwMask = 32'h8000_0000; send("R8 size 32 ok");
    baseline(); reqBpw = 8'd1; capBpwMask = 32'h0000_0002; send("R8 size 1 masked");
    baseline(); reqBpw = 8'd17; send("R8 zero mask");
    baseline(); capFreqMax = 32'd1000; reqFreq = 32'd1000; send("R9 at limit");
    baseline(); capFreqMax = 32'd1000; reqFreq = 32'd1001; send("R9 over");
    baseline(); capFreqMax = 32'd0; reqFreq = 32'hFFFF_FFFF; send("R9 unlimited");
    for (int k = 0; k < 4; k++) begin
      baseline(); reqDelays[k*32 +: 32] = 32'd100; send("R10 at max");
      baseline(); reqDelays[k*32 +: 32] = 32'd101; send("R10 over max");
      baseline(); capDelayMax[k*32 +: 32] = 32'd0; reqDelays[k*32 +: 32] = 32'd1; send("R10 zero max");
      baseline(); capDelayMax[k*32 +: 32] = 32'd0; send("R10 zero max zero req");
    end
    baseline(); reqCs = 8'd3; send("R11 last cs");
    baseline(); reqCs = 8'd4; send("R11 cs equal count");
    baseline(); reqCs = 8'd9; capModes[1:0] = 2'b11; send("R3 param over unsup");
    baseline(); capCsChange = 1'b0; reqCsChange = 1'b1; send("R12 toggle");
    baseline(); capCsChange = 1'b0; reqCsChange = 1'b0; send("R12 no toggle ok");

    for (int n = 0; n < 400; n++) begin
      randLegal();
      if ($urandom_range(0, 2) != 0) randBreak();
      if ($urandom_range(0, 3) == 0) randBreak();
      send("R3 random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule